// File: doc/BRIEF.md
# Six-Step Commutation Output Sequencer

This block drives three complementary output pairs, a channel and its complement for each of three phases, through a fixed six-step commutation pattern. Exactly two outputs are active in each step. The enable pattern for the next step waits in a shadow register. On a commutation event it is copied into the active set, so all six enables change on the same clock edge. A commutation event comes from a one-cycle software strobe or from a rising edge on a trigger input.

A free-running up counter provides the time base. Its wrap, the update event, re-arms the main output enable after a break. Every output that turns on is held back by a programmable number of dead-time clocks. An active-high break input clears the main output enable and forces all six outputs to their idle level, which is high. While the main output enable is set, outputs are active high and inactive outputs are driven low.

Top module: `sixstep_commutator`

## Requirements
- R1: The step value goes 1 to 6. `ch_out[i]` is the channel and `chn_out[i]` the complement of phase i+1. The active outputs per step are: step 1 ch1 and chn2; step 2 chn2 and ch3; step 3 chn1 and ch3; step 4 chn1 and ch2; step 5 ch2 and chn3; step 6 ch1 and chn3. All other outputs are low while the main output enable is set.
- R2: The enables switch only on a commutation event. All six are applied together. With zero dead time every output reflects the new step two cycles after the event edge and the old step one cycle after it.
- R3: A commutation event is a high `com_sw` at a clock edge, or `com_trig` high at an edge where it was low at the previous edge. A trigger held high, or falling, causes no event.
- R4: A software strobe and a trigger rising edge in the same cycle form a single event: the step advances by one.
- R5: The counter counts 0 to PERIOD and wraps to 0. With PRESCALE 0 it advances every clock. The clock on which it wraps is the update event.
- R6: An output that becomes active rises `dead_cfg` cycles later than it would with zero dead time. Outputs that turn off, or stay on, are not delayed. A channel and its complement are never high together while the main output enable is set.
- R7: One cycle after `brk_in` is seen high, `moe_out` is 0 and all six outputs are high. Commutation events still advance the step during a break.
- R8: After `brk_in` falls, `moe_out` stays 0 until the next update event and is 1 from that edge on. The outputs then show the current step.
- R9: `com_flag` is high for exactly the one cycle following each commutation event edge.
- R10: After reset the step is 1, `moe_out` is 0 and all outputs are high. A `moe_set` pulse with no break sets `moe_out` at the next edge.
- R11: Each event moves the step from s to s+1, and from 6 back to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| com_sw | input | 1 | Software commutation strobe |
| com_trig | input | 1 | Hardware commutation trigger (rising edge) |
| brk_in | input | 1 | Break, active high |
| moe_set | input | 1 | Set main output enable |
| dead_cfg | input | DT_W | Dead time in clocks |
| ch_out | output | 3 | Channel outputs, phases 1..3 |
| chn_out | output | 3 | Complement outputs, phases 1..3 |
| step_out | output | 3 | Current step, 1..6 |
| com_flag | output | 1 | One-cycle commutation flag |
| moe_out | output | 1 | Main output enable |
| cnt_out | output | CNT_W | Time base counter |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is the two commutation sources. The bench raises `com_sw` and a `com_trig` rising edge on the same clock edge and requires the step to move by exactly one, with a single flag pulse. The second pair is break and commutation. A strobe issued while `brk_in` is high must advance `step_out` while every output stays at its idle high level. The new pattern must appear only after the main output enable returns at the next counter wrap.

// File: rtl/sixstep_pkg.sv
package sixstep_pkg;
  localparam int NPH = 3;
  localparam int NOUT = 2 * NPH;

  typedef logic [2:0] step_t;

  localparam step_t STEP_FIRST = 3'd1;
  localparam step_t STEP_LAST  = 3'd6;

  // successor of a step, wrapping after the sixth
  function automatic step_t step_after(step_t s);
    return (s == STEP_LAST) ? STEP_FIRST : step_t'(s + 3'd1);
  endfunction

  // enable vector for a step: bits [2:0] channels ph1..ph3, bits [5:3] complements
  function automatic logic [NOUT-1:0] step_drive(step_t s);
    logic [NOUT-1:0] v;
    case (s)
      3'd1:    v = 6'b010_001;
      3'd2:    v = 6'b010_100;
      3'd3:    v = 6'b001_100;
      3'd4:    v = 6'b001_010;
      3'd5:    v = 6'b100_010;
      3'd6:    v = 6'b100_001;
      default: v = '0;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/sixstep_timebase.sv
module sixstep_timebase #(
  parameter int PRESCALE = 0,
  parameter int PERIOD   = 4095,
  parameter int CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt,
  output logic             upd
);
  logic tick;
  logic [CNT_W-1:0] cnt_q;

  generate
    if (PRESCALE == 0) begin : g_nopsc
      assign tick = 1'b1;
    end else begin : g_psc
      localparam int PSC_W = $clog2(PRESCALE + 1);
      logic [PSC_W-1:0] psc_q;
      always_ff @(posedge clk) begin
        if (rst)                             psc_q <= '0;
        else if (psc_q == PSC_W'(PRESCALE))  psc_q <= '0;
        else                                 psc_q <= psc_q + 1'b1;
      end
      assign tick = (psc_q == PSC_W'(PRESCALE));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)                               cnt_q <= '0;
    else if (tick) begin
      if (cnt_q == CNT_W'(PERIOD))         cnt_q <= '0;
      else                                 cnt_q <= cnt_q + 1'b1;
    end
  end

  assign upd = tick && (cnt_q == CNT_W'(PERIOD));
  assign cnt = cnt_q;

  a_r5_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
    upd |=> (cnt_q == '0));
  a_r5_within_period: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(PERIOD));
endmodule

// File: rtl/sixstep_commit.sv
module sixstep_commit
  import sixstep_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            sw,
  input  logic            trig,
  output logic [NOUT-1:0] en,
  output step_t           step,
  output logic            flag
);
  logic            trig_q;
  logic            ev;
  step_t           step_q, shadow_step_q;
  logic [NOUT-1:0] en_q, shadow_en_q;
  logic            flag_q;

  // one event even when both sources coincide
  assign ev = sw | (trig & ~trig_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_q        <= 1'b0;
      step_q        <= STEP_FIRST;
      en_q          <= step_drive(STEP_FIRST);
      shadow_step_q <= step_after(STEP_FIRST);
      shadow_en_q   <= step_drive(step_after(STEP_FIRST));
      flag_q        <= 1'b0;
    end else begin
      trig_q <= trig;
      flag_q <= ev;
      if (ev) begin
        step_q        <= shadow_step_q;
        en_q          <= shadow_en_q;
        shadow_step_q <= step_after(shadow_step_q);
        shadow_en_q   <= step_drive(step_after(shadow_step_q));
      end
    end
  end

  assign en   = en_q;
  assign step = step_q;
  assign flag = flag_q;

  a_r1_two_active: assert property (@(posedge clk) disable iff (rst)
    $countones(en_q) == 2);
  a_r2_hold_without_event: assert property (@(posedge clk) disable iff (rst)
    !ev |=> $stable(en_q) && $stable(step_q));
  a_r11_event_moves_step: assert property (@(posedge clk) disable iff (rst)
    ev |=> (step_q != $past(step_q)) && flag_q);
endmodule

// File: rtl/sixstep_deadband.sv
module sixstep_deadband #(
  parameter int DT_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req,
  input  logic [DT_W-1:0] dt,
  output logic            on
);
  logic [DT_W-1:0] wait_q;
  logic            on_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_q <= '0;
      on_q   <= 1'b0;
    end else if (!req) begin
      wait_q <= '0;
      on_q   <= 1'b0;
    end else if (wait_q >= dt) begin
      on_q   <= 1'b1;
    end else begin
      wait_q <= wait_q + 1'b1;
    end
  end

  assign on = on_q;

  a_r6_rise_needs_request: assert property (@(posedge clk) disable iff (rst)
    $rose(on_q) |-> $past(req));
  a_r6_fall_immediate: assert property (@(posedge clk) disable iff (rst)
    !req |=> !on_q);
endmodule

// File: rtl/sixstep_commutator.sv
module sixstep_commutator
  import sixstep_pkg::*;
#(
  parameter int PRESCALE = 0,
  parameter int PERIOD   = 4095,
  parameter int CNT_W    = 16,
  parameter int DT_W     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             com_sw,
  input  logic             com_trig,
  input  logic             brk_in,
  input  logic             moe_set,
  input  logic [DT_W-1:0]  dead_cfg,
  output logic [2:0]       ch_out,
  output logic [2:0]       chn_out,
  output logic [2:0]       step_out,
  output logic             com_flag,
  output logic             moe_out,
  output logic [CNT_W-1:0] cnt_out
);
  logic            upd;
  logic [NOUT-1:0] en;
  logic [NOUT-1:0] on;
  logic [NOUT-1:0] out_q;
  logic            moe_q;
  step_t           step;

  sixstep_timebase #(.PRESCALE(PRESCALE), .PERIOD(PERIOD), .CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst(rst), .cnt(cnt_out), .upd(upd)
  );

  sixstep_commit u_commit (
    .clk(clk), .rst(rst), .sw(com_sw), .trig(com_trig),
    .en(en), .step(step), .flag(com_flag)
  );

  genvar gi;
  generate
    for (gi = 0; gi < NOUT; gi++) begin : g_db
      sixstep_deadband #(.DT_W(DT_W)) u_db (
        .clk(clk), .rst(rst), .req(en[gi]), .dt(dead_cfg), .on(on[gi])
      );
    end
  endgenerate

  // main output enable: break clears, update event or explicit set re-arms
  always_ff @(posedge clk) begin
    if (rst)                  moe_q <= 1'b0;
    else if (brk_in)          moe_q <= 1'b0;
    else if (upd || moe_set)  moe_q <= 1'b1;
  end

  // output stage: idle level is high on every output
  always_ff @(posedge clk) begin
    if (rst)                   out_q <= '1;
    else if (brk_in || !moe_q) out_q <= '1;
    else                       out_q <= on;
  end

  assign ch_out   = out_q[NPH-1:0];
  assign chn_out  = out_q[NOUT-1:NPH];
  assign moe_out  = moe_q;
  assign step_out = step;

  a_r7_break_forces_idle: assert property (@(posedge clk) disable iff (rst)
    brk_in |=> (!moe_q && (&out_q)));
  a_r6_pair_exclusive: assert property (@(posedge clk) disable iff (rst)
    moe_q |-> ((on[NPH-1:0] & on[NOUT-1:NPH]) == '0));
  a_r8_no_rearm_in_break: assert property (@(posedge clk) disable iff (rst)
    (!moe_q && brk_in) |=> !moe_q);
endmodule

// File: tb/sixstep_commutator_bench.sv
module sixstep_commutator_bench;
  localparam int PERIOD = 31;
  localparam int DT_W   = 4;

  logic clk = 1'b0;
  logic rst, com_sw, com_trig, brk_in, moe_set;
  logic [DT_W-1:0] dead_cfg;
  logic [2:0] ch_out, chn_out, step_out;
  logic com_flag, moe_out;
  logic [15:0] cnt_out;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  sixstep_commutator #(.PERIOD(PERIOD), .DT_W(DT_W)) u_sixstep_commutator (
    .clk(clk), .rst(rst), .com_sw(com_sw), .com_trig(com_trig), .brk_in(brk_in),
    .moe_set(moe_set), .dead_cfg(dead_cfg), .ch_out(ch_out), .chn_out(chn_out),
    .step_out(step_out), .com_flag(com_flag), .moe_out(moe_out), .cnt_out(cnt_out)
  );

  // step table, bits [2:0] channels, [5:3] complements
  function automatic logic [5:0] pat(int s);
    case (s)
      1: return 6'b010_001;
      2: return 6'b010_100;
      3: return 6'b001_100;
      4: return 6'b001_010;
      5: return 6'b100_010;
      6: return 6'b100_001;
      default: return 6'b000_000;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] outs();
    return {chn_out, ch_out};
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int cur;
    int nxt;
    logic [5:0] prv, nw, e;
    rst = 1; com_sw = 0; com_trig = 0; brk_in = 0; moe_set = 0; dead_cfg = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    chk(step_out == 3'd1, "R10 reset step", step_out, 1);
    chk(moe_out == 1'b0, "R10 reset moe", moe_out, 0);
    chk(outs() == 6'h3f, "R10 reset idle high", outs(), 6'h3f);
    chk(com_flag == 1'b0, "R9 no flag after reset", com_flag, 0);

    moe_set = 1;
    @(negedge clk);
    moe_set = 0;
    chk(moe_out == 1'b1, "R10 moe_set", moe_out, 1);
    @(negedge clk);
    chk(outs() == pat(1), "R1 step1 pattern", outs(), pat(1));

    // R1 R2 R9 R11: two full rotations by strobe, zero dead time
    cur = 1;
    for (int i = 0; i < 12; i++) begin
      nxt = (cur == 6) ? 1 : cur + 1;
      prv = pat(cur);
      com_sw = 1;
      @(negedge clk);
      com_sw = 0;
      chk(step_out == 3'(nxt), "R11 step advance", step_out, nxt);
      chk(com_flag == 1'b1, "R9 flag raised", com_flag, 1);
      @(negedge clk);
      chk(com_flag == 1'b0, "R9 flag one cycle", com_flag, 0);
      chk(outs() == prv, "R2 old step one cycle after", outs(), prv);
      @(negedge clk);
      chk(outs() == pat(nxt), "R1 R2 all outputs switch together", outs(), pat(nxt));
      cur = nxt;
    end

    // R2 no event -> no change
    repeat (5) begin
      @(negedge clk);
      chk(outs() == pat(cur) && step_out == 3'(cur), "R2 hold without event", outs(), pat(cur));
    end

    // R3 trigger rising edge, held high, falling
    com_trig = 1;
    @(negedge clk);
    nxt = (cur == 6) ? 1 : cur + 1;
    chk(step_out == 3'(nxt), "R3 trigger rise event", step_out, nxt);
    cur = nxt;
    repeat (3) begin
      @(negedge clk);
      chk(step_out == 3'(cur) && !com_flag, "R3 held trigger no event", step_out, cur);
    end
    com_trig = 0;
    @(negedge clk);
    @(negedge clk);
    chk(step_out == 3'(cur), "R3 falling trigger no event", step_out, cur);

    // R4 coincident sources
    com_sw = 1; com_trig = 1;
    @(negedge clk);
    com_sw = 0; com_trig = 0;
    nxt = (cur == 6) ? 1 : cur + 1;
    chk(step_out == 3'(nxt), "R4 coincident single advance", step_out, nxt);
    chk(com_flag == 1'b1, "R4 coincident flag", com_flag, 1);
    @(negedge clk);
    chk(step_out == 3'(nxt) && !com_flag, "R4 no second event", step_out, nxt);
    cur = nxt;
    repeat (3) @(negedge clk);

    // R6 dead time sweep
    for (int d = 1; d <= 3; d++) begin
      dead_cfg = DT_W'(d);
      repeat (3) @(negedge clk);
      nxt = (cur == 6) ? 1 : cur + 1;
      prv = pat(cur);
      nw  = pat(nxt);
      com_sw = 1;
      @(negedge clk);
      com_sw = 0;
      for (int k = 0; k <= d + 2; k++) begin
        @(negedge clk);
        if (k == 0) e = prv;
        else e = (prv & nw) | ((k >= 1 + d) ? (nw & ~prv) : 6'b0);
        chk(outs() == e, "R6 dead time delay", outs(), e);
        chk((ch_out & chn_out) == 3'b0, "R6 pair exclusive", {ch_out, chn_out}, 0);
      end
      cur = nxt;
    end
    dead_cfg = '0;
    repeat (3) @(negedge clk);

    // R7 break forces idle, commutation still advances
    brk_in = 1;
    @(negedge clk);
    chk(outs() == 6'h3f, "R7 break idle", outs(), 6'h3f);
    chk(moe_out == 1'b0, "R7 break clears moe", moe_out, 0);
    com_sw = 1;
    @(negedge clk);
    com_sw = 0;
    nxt = (cur == 6) ? 1 : cur + 1;
    chk(step_out == 3'(nxt), "R7 step advances during break", step_out, nxt);
    cur = nxt;
    repeat (3) begin
      @(negedge clk);
      chk(outs() == 6'h3f, "R7 idle held during break", outs(), 6'h3f);
    end
    brk_in = 0;

    // R8 re-enable at next update event
    begin
      bit seen = 0;
      int early = 0;
      for (int j = 0; j < 2 * (PERIOD + 1) && !seen; j++) begin
        @(negedge clk);
        if (cnt_out == 16'd0) begin
          seen = 1;
          chk(moe_out == 1'b1, "R8 moe set at update", moe_out, 1);
        end else if (moe_out) early++;
      end
      chk(seen && early == 0, "R8 moe stays clear until update", early, 0);
    end
    @(negedge clk);
    chk(outs() == pat(cur), "R8 pattern after re-enable", outs(), pat(cur));

    // R5 counter sweep
    begin
      int bad = 0;
      logic [15:0] pc;
      @(negedge clk);
      pc = cnt_out;
      for (int j = 0; j < 3 * (PERIOD + 1); j++) begin
        @(negedge clk);
        if (cnt_out != ((pc == 16'(PERIOD)) ? 16'd0 : pc + 16'd1)) bad++;
        pc = cnt_out;
      end
      chk(bad == 0, "R5 counter wraps at PERIOD", bad, 0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule